// File: doc/BRIEF.md
# Scalar-to-Vector Element Loop Sequencer

This block sits between instruction decode and the execution units. It accepts one decoded scalar instruction, made up of an opcode tag, a destination register, two source registers and a flag that says whether the operation consumes a carry. When vector mode is on, it replays that instruction as a run of element micro-ops, one for each element. Each element adds its element index to all three register numbers. When vector mode is off, the instruction leaves as exactly one micro-op with its register numbers unchanged.

Each element has its own carry bit. All of these bits sit in one 8-bit carry register, which software can read and overwrite when it saves and restores a context. Execution units return per-element results on a writeback port: a carry-out, an overflow flag and a saturation flag, each tagged with the element index that came with the micro-op. Each micro-op also names the condition field it updates: field 6 while vector mode is active, field 0 otherwise.

Top module: `vec_elem_seq`

## Requirements
- R1: `in_ready` is high whenever no instruction is in progress. An instruction is taken on a cycle with `in_valid` and `in_ready` both high, and its first micro-op (index 0) is valid in the next cycle.
- R2: With `vec_en` high at acceptance, the block emits exactly L micro-ops, where L is the effective vector length. `uop_idx` runs 0..L-1, and `uop_last` is high only on index L-1.
- R3: Element i carries `uop_rd`, `uop_rs1` and `uop_rs2` equal to the instruction's base numbers plus i, modulo 32.
- R4: With `vec_en` low, or with an effective length of 1, the block emits exactly one micro-op: index 0, `uop_last` high, and register numbers unchanged.
- R5: A `vec_len` of 0 is treated as 1 element. Values from 9 to 15 are treated as 8 elements. Values from 1 to 8 are used as given. With `vec_en` low, `vec_len` is ignored.
- R6: While any micro-op of the current instruction is still outstanding, `in_ready` is low and `in_valid` has no effect. `in_ready` goes high in the cycle after the last micro-op is accepted.
- R7: While `uop_valid` is high and `uop_ready` is low, every micro-op output holds its value.
- R8: `uop_cin` equals bit `uop_idx` of the carry register when `uop_use_carry` is set, and 0 otherwise. A scalar pass-through therefore uses bit 0.
- R9: When `wb_valid` and `wb_carry_we` are both high, bit `wb_idx` of the carry register takes `wb_carry` on the next cycle. The other bits are unchanged. With `wb_carry_we` low, the carry register is not changed.
- R10: `csr_wr_en` loads all 8 bits of `csr_wdata` into the carry register, readable on `csr_rdata` the next cycle. It takes priority over a carry writeback in the same cycle.
- R11: `uop_crf` is 6 when `vec_en` was high at acceptance, and 0 otherwise.
- R12: When `wb_valid` is high, bit `wb_idx` of `elem_ovf` takes `wb_ovf` and bit `wb_idx` of `elem_sat` takes `wb_sat` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_en | input | 1 | Vector mode enable, sampled at acceptance |
| vec_len | input | 4 | Requested element count, sampled at acceptance |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_op | input | 6 | Opcode tag |
| in_rd | input | 5 | Base destination register |
| in_rs1 | input | 5 | Base first source register |
| in_rs2 | input | 5 | Base second source register |
| in_use_carry | input | 1 | Instruction consumes and produces carry |
| uop_valid | output | 1 | Micro-op valid |
| uop_ready | input | 1 | Downstream accepts micro-op |
| uop_op | output | 6 | Opcode tag of micro-op |
| uop_rd | output | 5 | Element destination register |
| uop_rs1 | output | 5 | Element first source register |
| uop_rs2 | output | 5 | Element second source register |
| uop_idx | output | 3 | Element index |
| uop_last | output | 1 | Final element of the instruction |
| uop_use_carry | output | 1 | Carry flag passed through |
| uop_cin | output | 1 | Element carry-in |
| uop_crf | output | 3 | Target condition field |
| wb_valid | input | 1 | Element result flags returned |
| wb_idx | input | 3 | Element index of returned flags |
| wb_carry_we | input | 1 | Write the returned carry-out |
| wb_carry | input | 1 | Element carry-out |
| wb_ovf | input | 1 | Element overflow flag |
| wb_sat | input | 1 | Element saturation flag |
| csr_wr_en | input | 1 | Software write of carry register |
| csr_wdata | input | 8 | Carry register write data |
| csr_rdata | output | 8 | Carry register contents |
| elem_ovf | output | 8 | Per-element overflow flags |
| elem_sat | output | 8 | Per-element saturation flags |

## Verification
An accepted instruction shows its element 0 one cycle later. Each later element appears one cycle after the previous one is taken, and `in_ready` returns one cycle after the last one is taken. Carry, overflow and saturation writebacks, and software writes of the carry register, become visible on the outputs one cycle after the cycle in which they were driven. `uop_cin` follows the carry register combinationally. The bench drives every input on the falling edge and reads every output on the next falling edge after the rising edge that is due to change it. In this way, each element of a run is checked in the half cycle before its handshake.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ISSUE = 1'b1
    } seq_state_e;

    localparam int          CRF_W      = 3;
    localparam logic [2:0]  CRF_SCALAR = 3'd0;
    localparam logic [2:0]  CRF_VECTOR = 3'd6;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl #(
    parameter int OP_W      = 6,
    parameter int REG_W     = 5,
    parameter int LEN_W     = 4,
    parameter int MAX_ELEMS = 8,
    localparam int IDX_W    = $clog2(MAX_ELEMS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        vec_en,
    input  logic [LEN_W-1:0]            vec_len,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [OP_W-1:0]             in_op,
    input  logic [REG_W-1:0]            in_rd,
    input  logic [REG_W-1:0]            in_rs1,
    input  logic [REG_W-1:0]            in_rs2,
    input  logic                        in_use_carry,
    output logic                        uop_valid,
    input  logic                        uop_ready,
    output logic [OP_W-1:0]             uop_op,
    output logic [REG_W-1:0]            uop_rd,
    output logic [REG_W-1:0]            uop_rs1,
    output logic [REG_W-1:0]            uop_rs2,
    output logic [IDX_W-1:0]            uop_idx,
    output logic                        uop_last,
    output logic                        uop_use_carry,
    output logic [vseq_pkg::CRF_W-1:0]  uop_crf
);
    import vseq_pkg::*;

    typedef struct packed {
        seq_state_e         state;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last_idx;
        logic               vmode;
        logic [OP_W-1:0]    op;
        logic [REG_W-1:0]   rd;
        logic [REG_W-1:0]   rs1;
        logic [REG_W-1:0]   rs2;
        logic               use_carry;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    logic [IDX_W-1:0] len_m1;

    // Effective length minus one: scalar mode and zero give 0, large values clamp.
    always_comb begin
        if (!vec_en || (vec_len == '0)) begin
            len_m1 = '0;
        end else if (int'(vec_len) >= MAX_ELEMS) begin
            len_m1 = IDX_W'(MAX_ELEMS - 1);
        end else begin
            len_m1 = IDX_W'(vec_len - 1'b1);
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            SEQ_IDLE: begin
                if (in_valid) begin
                    st_d.state     = SEQ_ISSUE;
                    st_d.idx       = '0;
                    st_d.last_idx  = len_m1;
                    st_d.vmode     = vec_en;
                    st_d.op        = in_op;
                    st_d.rd        = in_rd;
                    st_d.rs1       = in_rs1;
                    st_d.rs2       = in_rs2;
                    st_d.use_carry = in_use_carry;
                end
            end
            SEQ_ISSUE: begin
                if (uop_ready) begin
                    if (st_q.idx == st_q.last_idx) begin
                        st_d.state = SEQ_IDLE;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            default: st_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready      = (st_q.state == SEQ_IDLE);
    assign uop_valid     = (st_q.state == SEQ_ISSUE);
    assign uop_op        = st_q.op;
    assign uop_rd        = st_q.rd  + REG_W'(st_q.idx);
    assign uop_rs1       = st_q.rs1 + REG_W'(st_q.idx);
    assign uop_rs2       = st_q.rs2 + REG_W'(st_q.idx);
    assign uop_idx       = st_q.idx;
    assign uop_last      = (st_q.idx == st_q.last_idx);
    assign uop_use_carry = st_q.use_carry;
    assign uop_crf       = st_q.vmode ? CRF_VECTOR : CRF_SCALAR;
endmodule

// File: rtl/vseq_elem_state.sv
module vseq_elem_state #(
    parameter int MAX_ELEMS = 8,
    localparam int IDX_W    = $clog2(MAX_ELEMS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wb_valid,
    input  logic [IDX_W-1:0]      wb_idx,
    input  logic                  wb_carry_we,
    input  logic                  wb_carry,
    input  logic                  wb_ovf,
    input  logic                  wb_sat,
    input  logic                  csr_wr_en,
    input  logic [MAX_ELEMS-1:0]  csr_wdata,
    output logic [MAX_ELEMS-1:0]  carry_vec,
    output logic [MAX_ELEMS-1:0]  ovf_vec,
    output logic [MAX_ELEMS-1:0]  sat_vec
);
    typedef struct packed {
        logic [MAX_ELEMS-1:0] carry;
        logic [MAX_ELEMS-1:0] ovf;
        logic [MAX_ELEMS-1:0] sat;
    } elem_st_t;

    elem_st_t             st_d, st_q;
    logic [MAX_ELEMS-1:0] hit;

    for (genvar g = 0; g < MAX_ELEMS; g++) begin : g_hit
        assign hit[g] = wb_valid && (wb_idx == IDX_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < MAX_ELEMS; i++) begin
            if (hit[i]) begin
                st_d.ovf[i] = wb_ovf;
                st_d.sat[i] = wb_sat;
                if (wb_carry_we) begin
                    st_d.carry[i] = wb_carry;
                end
            end
        end
        // Software restore wins over any element writeback in the same cycle.
        if (csr_wr_en) begin
            st_d.carry = csr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry_vec = st_q.carry;
    assign ovf_vec   = st_q.ovf;
    assign sat_vec   = st_q.sat;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
    parameter int OP_W      = 6,
    parameter int REG_W     = 5,
    parameter int LEN_W     = 4,
    parameter int MAX_ELEMS = 8,
    localparam int IDX_W    = $clog2(MAX_ELEMS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vec_en,
    input  logic [LEN_W-1:0]      vec_len,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [OP_W-1:0]       in_op,
    input  logic [REG_W-1:0]      in_rd,
    input  logic [REG_W-1:0]      in_rs1,
    input  logic [REG_W-1:0]      in_rs2,
    input  logic                  in_use_carry,
    output logic                  uop_valid,
    input  logic                  uop_ready,
    output logic [OP_W-1:0]       uop_op,
    output logic [REG_W-1:0]      uop_rd,
    output logic [REG_W-1:0]      uop_rs1,
    output logic [REG_W-1:0]      uop_rs2,
    output logic [IDX_W-1:0]      uop_idx,
    output logic                  uop_last,
    output logic                  uop_use_carry,
    output logic                  uop_cin,
    output logic [2:0]            uop_crf,
    input  logic                  wb_valid,
    input  logic [IDX_W-1:0]      wb_idx,
    input  logic                  wb_carry_we,
    input  logic                  wb_carry,
    input  logic                  wb_ovf,
    input  logic                  wb_sat,
    input  logic                  csr_wr_en,
    input  logic [MAX_ELEMS-1:0]  csr_wdata,
    output logic [MAX_ELEMS-1:0]  csr_rdata,
    output logic [MAX_ELEMS-1:0]  elem_ovf,
    output logic [MAX_ELEMS-1:0]  elem_sat
);
    logic [MAX_ELEMS-1:0] carry_vec;

    vseq_ctrl #(
        .OP_W      (OP_W),
        .REG_W     (REG_W),
        .LEN_W     (LEN_W),
        .MAX_ELEMS (MAX_ELEMS)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .vec_en        (vec_en),
        .vec_len       (vec_len),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_op         (in_op),
        .in_rd         (in_rd),
        .in_rs1        (in_rs1),
        .in_rs2        (in_rs2),
        .in_use_carry  (in_use_carry),
        .uop_valid     (uop_valid),
        .uop_ready     (uop_ready),
        .uop_op        (uop_op),
        .uop_rd        (uop_rd),
        .uop_rs1       (uop_rs1),
        .uop_rs2       (uop_rs2),
        .uop_idx       (uop_idx),
        .uop_last      (uop_last),
        .uop_use_carry (uop_use_carry),
        .uop_crf       (uop_crf)
    );

    vseq_elem_state #(
        .MAX_ELEMS (MAX_ELEMS)
    ) u_elem (
        .clk         (clk),
        .rst_n       (rst_n),
        .wb_valid    (wb_valid),
        .wb_idx      (wb_idx),
        .wb_carry_we (wb_carry_we),
        .wb_carry    (wb_carry),
        .wb_ovf      (wb_ovf),
        .wb_sat      (wb_sat),
        .csr_wr_en   (csr_wr_en),
        .csr_wdata   (csr_wdata),
        .carry_vec   (carry_vec),
        .ovf_vec     (elem_ovf),
        .sat_vec     (elem_sat)
    );

    assign uop_cin   = uop_use_carry & carry_vec[uop_idx];
    assign csr_rdata = carry_vec;
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
    parameter int OP_W      = 6,
    parameter int REG_W     = 5,
    parameter int MAX_ELEMS = 8,
    localparam int IDX_W    = $clog2(MAX_ELEMS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  uop_valid,
    input logic                  uop_ready,
    input logic [OP_W-1:0]       uop_op,
    input logic [REG_W-1:0]      uop_rd,
    input logic [IDX_W-1:0]      uop_idx,
    input logic                  uop_last,
    input logic                  uop_use_carry,
    input logic                  uop_cin,
    input logic [2:0]            uop_crf,
    input logic                  wb_valid,
    input logic [IDX_W-1:0]      wb_idx,
    input logic                  wb_ovf,
    input logic                  csr_wr_en,
    input logic [MAX_ELEMS-1:0]  csr_wdata,
    input logic [MAX_ELEMS-1:0]  csr_rdata,
    input logic [MAX_ELEMS-1:0]  elem_ovf
);
    AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (uop_valid && (uop_idx == '0))); // R1

    AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && !uop_last) |=>
            (uop_valid && (uop_idx == IDX_W'($past(uop_idx) + 1'b1))
                       && (uop_rd == REG_W'($past(uop_rd) + 1'b1)))); // R3

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> !in_ready); // R6

    AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && uop_last) |=> in_ready); // R6

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=>
            (uop_valid && $stable(uop_rd) && $stable(uop_idx)
                       && $stable(uop_op) && $stable(uop_last))); // R7

    AST_CIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_use_carry) |-> !uop_cin); // R8

    AST_CSR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_en |=> (csr_rdata == $past(csr_wdata))); // R10

    AST_LATER_ELEM_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && (uop_idx != '0)) |-> (uop_crf == 3'd6)); // R11

    AST_FLAG_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> (elem_ovf[$past(wb_idx)] == $past(wb_ovf))); // R12
endmodule

bind vec_elem_seq vseq_checker #(
    .OP_W      (OP_W),
    .REG_W     (REG_W),
    .MAX_ELEMS (MAX_ELEMS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .uop_valid     (uop_valid),
    .uop_ready     (uop_ready),
    .uop_op        (uop_op),
    .uop_rd        (uop_rd),
    .uop_idx       (uop_idx),
    .uop_last      (uop_last),
    .uop_use_carry (uop_use_carry),
    .uop_cin       (uop_cin),
    .uop_crf       (uop_crf),
    .wb_valid      (wb_valid),
    .wb_idx        (wb_idx),
    .wb_ovf        (wb_ovf),
    .csr_wr_en     (csr_wr_en),
    .csr_wdata     (csr_wdata),
    .csr_rdata     (csr_rdata),
    .elem_ovf      (elem_ovf)
);

// File: tb/vec_elem_seq_bench.sv
`timescale 1ns/1ps
module vec_elem_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vec_en = 1'b0;
    logic [3:0] vec_len = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [5:0] in_op = '0;
    logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic       in_use_carry = 1'b0;
    logic       uop_valid;
    logic       uop_ready = 1'b1;
    logic [5:0] uop_op;
    logic [4:0] uop_rd, uop_rs1, uop_rs2;
    logic [2:0] uop_idx;
    logic       uop_last, uop_use_carry, uop_cin;
    logic [2:0] uop_crf;
    logic       wb_valid = 1'b0;
    logic [2:0] wb_idx = '0;
    logic       wb_carry_we = 1'b0, wb_carry = 1'b0, wb_ovf = 1'b0, wb_sat = 1'b0;
    logic       csr_wr_en = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic [7:0] csr_rdata, elem_ovf, elem_sat;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vec_elem_seq u_vec_elem_seq (
        .clk(clk), .rst_n(rst_n), .vec_en(vec_en), .vec_len(vec_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_rd(in_rd),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .in_use_carry(in_use_carry),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_op(uop_op),
        .uop_rd(uop_rd), .uop_rs1(uop_rs1), .uop_rs2(uop_rs2), .uop_idx(uop_idx),
        .uop_last(uop_last), .uop_use_carry(uop_use_carry), .uop_cin(uop_cin),
        .uop_crf(uop_crf), .wb_valid(wb_valid), .wb_idx(wb_idx),
        .wb_carry_we(wb_carry_we), .wb_carry(wb_carry), .wb_ovf(wb_ovf),
        .wb_sat(wb_sat), .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .elem_ovf(elem_ovf), .elem_sat(elem_sat)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Offer an instruction on a falling edge; it is taken at the next rising edge.
    task automatic issue(input int op, input int rd, input int rs1, input int rs2,
                         input bit uc, input bit ven, input int len);
        @(negedge clk);
        vec_en = ven; vec_len = 4'(len); in_op = 6'(op);
        in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2);
        in_use_carry = uc; in_valid = 1'b1;
        chk("R1", "in_ready before accept", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Called on the falling edge where element 0 is due; checks every element.
    task automatic collect(input string req, input int op, input int rd, input int rs1,
                           input int rs2, input int n, input bit vm, input bit uc,
                           input logic [7:0] cval);
        uop_ready = 1'b1;
        for (int e = 0; e < n; e++) begin
            chk(req, "uop_valid", 32'(uop_valid), 32'd1);
            chk("R2", "uop_idx", 32'(uop_idx), 32'(e));
            chk("R2", "uop_last", 32'(uop_last), 32'(e == n - 1));
            chk("R3", "uop_rd", 32'(uop_rd), 32'((rd + e) % 32));
            chk("R3", "uop_rs1", 32'(uop_rs1), 32'((rs1 + e) % 32));
            chk("R3", "uop_rs2", 32'(uop_rs2), 32'((rs2 + e) % 32));
            chk(req, "uop_op", 32'(uop_op), 32'(op));
            chk("R11", "uop_crf", 32'(uop_crf), vm ? 32'd6 : 32'd0);
            chk("R8", "uop_cin", 32'(uop_cin), uc ? 32'(cval[e]) : 32'd0);
            chk("R6", "in_ready while busy", 32'(in_ready), 32'd0);
            @(negedge clk);
        end
        chk(req, "uop_valid after last", 32'(uop_valid), 32'd0);
        chk("R6", "in_ready after last", 32'(in_ready), 32'd1);
    endtask

    task automatic t_reset();
        chk("R1", "reset in_ready", 32'(in_ready), 32'd1);
        chk("R1", "reset uop_valid", 32'(uop_valid), 32'd0);
        chk("R10", "reset carry", 32'(csr_rdata), 32'd0);
        chk("R12", "reset ovf", 32'(elem_ovf), 32'd0);
        chk("R12", "reset sat", 32'(elem_sat), 32'd0);
    endtask

    task automatic csr_write(input logic [7:0] v);
        @(negedge clk);
        csr_wr_en = 1'b1; csr_wdata = v;
        @(negedge clk);
        csr_wr_en = 1'b0;
        chk("R10", "carry after write", 32'(csr_rdata), 32'(v));
    endtask

    task automatic t_vector_full();
        csr_write(8'hA5);
        issue(5, 3, 10, 20, 1'b1, 1'b1, 8);
        collect("R2", 5, 3, 10, 20, 8, 1'b1, 1'b1, 8'hA5);
    endtask

    task automatic t_wrap();
        issue(9, 30, 31, 29, 1'b0, 1'b1, 4);
        collect("R3", 9, 30, 31, 29, 4, 1'b1, 1'b0, 8'hA5);
    endtask

    task automatic t_scalar();
        issue(12, 7, 8, 9, 1'b1, 1'b0, 5);
        collect("R4", 12, 7, 8, 9, 1, 1'b0, 1'b1, 8'hA5);
        issue(13, 4, 5, 6, 1'b1, 1'b1, 1);
        collect("R4", 13, 4, 5, 6, 1, 1'b1, 1'b1, 8'hA5);
    endtask

    task automatic t_clamp();
        issue(2, 1, 2, 3, 1'b0, 1'b1, 0);
        collect("R5", 2, 1, 2, 3, 1, 1'b1, 1'b0, 8'hA5);
        issue(3, 16, 0, 8, 1'b0, 1'b1, 12);
        collect("R5", 3, 16, 0, 8, 8, 1'b1, 1'b0, 8'hA5);
    endtask

    task automatic t_stall();
        issue(21, 10, 11, 12, 1'b0, 1'b1, 3);
        uop_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R7", "stalled valid", 32'(uop_valid), 32'd1);
            chk("R7", "stalled idx", 32'(uop_idx), 32'd0);
            chk("R7", "stalled rd", 32'(uop_rd), 32'd10);
            @(negedge clk);
        end
        collect("R7", 21, 10, 11, 12, 3, 1'b1, 1'b0, 8'hA5);
    endtask

    task automatic t_busy();
        issue(33, 2, 4, 6, 1'b0, 1'b1, 3);
        // A second instruction is offered while the first is still running.
        vec_en = 1'b0; vec_len = 4'd7; in_op = 6'd44;
        in_rd = 5'd20; in_rs1 = 5'd21; in_rs2 = 5'd22; in_valid = 1'b1;
        collect("R6", 33, 2, 4, 6, 3, 1'b1, 1'b0, 8'hA5);
        @(negedge clk);
        in_valid = 1'b0;
        collect("R6", 44, 20, 21, 22, 1, 1'b0, 1'b0, 8'hA5);
    endtask

    task automatic wb(input int idx, input bit we, input bit c, input bit o, input bit s);
        @(negedge clk);
        wb_valid = 1'b1; wb_idx = 3'(idx); wb_carry_we = we;
        wb_carry = c; wb_ovf = o; wb_sat = s;
        @(negedge clk);
        wb_valid = 1'b0; wb_carry_we = 1'b0;
    endtask

    task automatic t_writeback();
        wb(2, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R9", "carry bit 2 cleared", 32'(csr_rdata), 32'hA1);
        wb(6, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R9", "carry bit 6 set", 32'(csr_rdata), 32'hE1);
        chk("R12", "ovf flags", 32'(elem_ovf), 32'h04);
        chk("R12", "sat flags", 32'(elem_sat), 32'h40);
        wb(0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9", "carry untouched without write enable", 32'(csr_rdata), 32'hE1);
        // Software write and element writeback collide.
        @(negedge clk);
        csr_wr_en = 1'b1; csr_wdata = 8'h3C;
        wb_valid = 1'b1; wb_idx = 3'd0; wb_carry_we = 1'b1; wb_carry = 1'b1;
        wb_ovf = 1'b1; wb_sat = 1'b0;
        @(negedge clk);
        csr_wr_en = 1'b0; wb_valid = 1'b0; wb_carry_we = 1'b0;
        chk("R10", "software write wins", 32'(csr_rdata), 32'h3C);
        chk("R12", "ovf bit 0 still written", 32'(elem_ovf), 32'h05);
        issue(50, 0, 8, 16, 1'b1, 1'b1, 8);
        collect("R8", 50, 0, 8, 16, 8, 1'b1, 1'b1, 8'h3C);
    endtask

    bit done = 1'b0;

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vector_full();
        t_wrap();
        t_scalar();
        t_clamp();
        t_stall();
        t_busy();
        t_writeback();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule